// File: doc/BRIEF.md
# Hammerstein Distortion Post-Corrector

This block removes second- and third-order distortion from the sample stream of a data converter while the stream is running. It takes one signed 12-bit sample on every clock, with no gaps. Each sample is raised to four times the sample rate by linear interpolation. Squared and cubed copies of the raised stream are then formed. Each copy passes through its own short programmable filter, so that every power term has its own frequency shaping. The filtered terms are summed, smoothed and reduced back to one value per sample. That correction is subtracted from a copy of the input that has been delayed to the same latency, and the result is clipped to the 12-bit range.

Forming the power terms at four times the rate means that harmonics which would fold back into the band are represented without ambiguity before the rate is reduced. The branch coefficients are produced elsewhere by a calibration step. They are loaded through a small address/data write port and then held fixed while the datapath is in use. A bypass input passes the aligned input through unchanged with the same latency, so the corrected and uncorrected streams can be switched without a timing step.

Top module: `hdc_post_corrector`

## Requirements
- R1: While `rst` is high, `y_out` is 0 after each clock edge, and every branch coefficient is cleared to 0.
- R2: A sample presented on `x_in` and taken at rising edge k produces its output on `y_out` just after rising edge k+4. One output is produced per clock, with no gaps.
- R3: For input sample n, four raised values are formed, with phase q = 0..3 equal to floor((q*x[n] + (4-q)*x[n-1]) / 4).
- R4: From each raised value w, the square term is floor(w*w / 2^11) and the cube term is floor(w*w*w / 2^22).
- R5: The correction for sample n is floor(A / 2^17), where A is the sum over filter tap j = 0..3 and smoothing offset k = 0..3 of c2[j]*S[4n+3-j-k] + c3[j]*C[4n+3-j-k]. S and C are the square and cube streams at four times the rate, and index 4m+q is phase q of sample m.
- R6: Without bypass, the output is x[n] minus the correction for sample n.
- R7: The output saturates to the range -2048..2047 instead of wrapping.
- R8: When `bypass` is high at the edge that produces the output, the output equals x[n] unchanged, with the same latency as in R2.
- R9: A write with `cfg_we` high and `run_en` low at a rising edge loads `cfg_data` as a two's-complement Q1.15 value into one coefficient. `cfg_addr` bit 2 selects the branch (0 for square, 1 for cube), and bits 1:0 select tap j.
- R10: A write made while `run_en` is high is ignored, and the coefficients keep their previous values.
- R11: When every coefficient is 0, the output equals the delayed input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 12 | Signed input sample, one per clock |
| bypass | input | 1 | Pass the aligned input straight to the output |
| run_en | input | 1 | High while the block is in use; blocks coefficient writes |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 3 | Bit 2 selects the branch (0 square, 1 cube); bits 1:0 select the tap |
| cfg_data | input | 16 | Coefficient value, signed Q1.15 |
| y_out | output | 12 | Corrected (or bypassed) signed output sample |

## Verification
Every output is due exactly four rising edges after the edge that takes its sample. The bench tags each expected value with the cycle count at which that edge has passed and compares it on the falling edge of that cycle, so there is no search window. The bypass and coefficient settings act on samples that are already inside the pipeline. For that reason, before any setting changes, the bench drives six filler samples that it does not check. Every checked sample therefore passes through the whole pipeline under one configuration. The expected arithmetic is recomputed in the bench with explicit floor division on 64-bit integers, and the bench confirms that the saturation stimulus actually reached both rails.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  localparam int SW  = 12;            // sample width
  localparam int UP  = 4;             // rate-raise factor
  localparam int UPL = $clog2(UP);
  localparam int TW  = SW + 1;        // power-term width (square reaches +2^(SW-1))

  typedef logic signed [SW-1:0] samp_t;
  typedef logic signed [TW-1:0] term_t;

  // Linear interpolation phase q between previous and current sample (floor).
  function automatic samp_t interp_phase(input samp_t cur, input samp_t prev, input int q);
    int a;
    a = int'(cur) * q + int'(prev) * (UP - q);
    return samp_t'(a >>> UPL);
  endfunction

  // Square normalised to full scale: w*w / 2^(SW-1), floor.
  function automatic term_t sq_term(input samp_t w);
    longint p;
    p = longint'(w) * longint'(w);
    return term_t'(p >>> (SW - 1));
  endfunction

  // Cube normalised to full scale: w^3 / 2^(2*(SW-1)), floor.
  function automatic term_t cube_term(input samp_t w);
    longint p;
    p = longint'(w) * longint'(w) * longint'(w);
    return term_t'(p >>> (2 * (SW - 1)));
  endfunction

  // Clip to the signed sample range.
  function automatic samp_t sat_samp(input longint v);
    longint hi;
    longint lo;
    hi = (64'sd1 <<< (SW - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (v > hi) return samp_t'(hi);
    if (v < lo) return samp_t'(lo);
    return samp_t'(v);
  endfunction
endpackage

// File: rtl/hdc_interp.sv
module hdc_interp
  import hdc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  samp_t           x_i,
  output samp_t [UP-1:0]  w_o
);
  samp_t      cur_q;
  samp_t      prev_q;
  logic [1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      prev_q <= '0;
      w_o    <= '0;
      age_q  <= '0;
    end else begin
      cur_q  <= x_i;
      prev_q <= cur_q;
      for (int q = 0; q < UP; q++) w_o[q] <= interp_phase(cur_q, prev_q, q);
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  // R3: phase 0 reproduces the sample taken three edges earlier
  assert_phase0_R3: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd3) |-> ($signed(w_o[0]) == $past($signed(x_i), 3)));
endmodule

// File: rtl/hdc_power.sv
module hdc_power
  import hdc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  samp_t [UP-1:0]  w_i,
  output term_t [UP-1:0]  sq_cur,
  output term_t [UP-1:0]  sq_prev,
  output term_t [UP-1:0]  cu_cur,
  output term_t [UP-1:0]  cu_prev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sq_cur  <= '0;
      sq_prev <= '0;
      cu_cur  <= '0;
      cu_prev <= '0;
    end else begin
      for (int q = 0; q < UP; q++) begin
        sq_cur[q] <= sq_term(w_i[q]);
        cu_cur[q] <= cube_term(w_i[q]);
      end
      sq_prev <= sq_cur;
      cu_prev <= cu_cur;
    end
  end

  for (genvar g = 0; g < UP; g++) begin : g_chk
    // R4: square term never negative
    assert_sq_nonneg_R4: assert property (@(posedge clk) disable iff (rst)
      $signed(sq_cur[g]) >= 0);
    // R4: cube term keeps the sign of its operand
    assert_cube_sign_R4: assert property (@(posedge clk) disable iff (rst)
      ($signed(cu_cur[g]) < 0) == ($past($signed(w_i[g])) < 0));
  end
endmodule

// File: rtl/hdc_coef_bank.sv
module hdc_coef_bank #(
  parameter  int CW   = 16,
  parameter  int TAPS = 4,
  localparam int TIW  = $clog2(TAPS),
  localparam int AAW  = TIW + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run_en,
  input  logic                      cfg_we,
  input  logic [AAW-1:0]            cfg_addr,
  input  logic [CW-1:0]             cfg_data,
  output logic [TAPS-1:0][CW-1:0]   c2_o,
  output logic [TAPS-1:0][CW-1:0]   c3_o
);
  logic wr_ok;
  assign wr_ok = cfg_we && !run_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      c2_o <= '0;
      c3_o <= '0;
    end else if (wr_ok) begin
      if (cfg_addr[TIW]) c3_o[cfg_addr[TIW-1:0]] <= cfg_data;
      else               c2_o[cfg_addr[TIW-1:0]] <= cfg_data;
    end
  end

  // R10: coefficients hold while the datapath is marked running
  assert_locked_R10: assert property (@(posedge clk) disable iff (rst)
    run_en |=> ($stable(c2_o) && $stable(c3_o)));
  // R9: an accepted square-branch write lands in the addressed tap
  assert_write_sq_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !run_en && !cfg_addr[TIW]) |=>
      (c2_o[$past(cfg_addr[TIW-1:0])] == $past(cfg_data)));
endmodule

// File: rtl/hdc_branch_acc.sv
module hdc_branch_acc
  import hdc_pkg::*;
#(
  parameter int CW   = 16,
  parameter int TAPS = 4,       // at most UP+1: the window spans two sample groups
  parameter int AW   = 35
) (
  input  logic                     clk,
  input  logic                     rst,
  input  term_t [UP-1:0]           sq_cur,
  input  term_t [UP-1:0]           sq_prev,
  input  term_t [UP-1:0]           cu_cur,
  input  term_t [UP-1:0]           cu_prev,
  input  logic [TAPS-1:0][CW-1:0]  c2_i,
  input  logic [TAPS-1:0][CW-1:0]  c3_i,
  output logic signed [AW-1:0]     acc_o
);
  localparam int SPAN = UP + TAPS - 1;   // raised-rate samples feeding one output

  term_t             seq2 [SPAN];
  term_t             seq3 [SPAN];
  logic signed [AW-1:0] sum;

  // seq[i] is the raised-rate term i steps before the last phase of the group
  always_comb begin
    for (int i = 0; i < SPAN; i++) begin
      if (i < UP) begin
        seq2[i] = sq_cur[UP-1-i];
        seq3[i] = cu_cur[UP-1-i];
      end else begin
        seq2[i] = sq_prev[2*UP-1-i];
        seq3[i] = cu_prev[2*UP-1-i];
      end
    end
    sum = '0;
    for (int k = 0; k < UP; k++)          // smoothing before keeping one of UP
      for (int j = 0; j < TAPS; j++)      // branch filter taps
        sum = sum + AW'($signed(c2_i[j])) * AW'(seq2[k+j])
                  + AW'($signed(c3_i[j])) * AW'(seq3[k+j]);
  end

  always_ff @(posedge clk) begin
    if (rst) acc_o <= '0;
    else     acc_o <= sum;
  end

  // R11: an all-zero coefficient set yields no correction
  assert_zero_coef_R11: assert property (@(posedge clk) disable iff (rst)
    $past((c2_i == '0) && (c3_i == '0)) |-> (acc_o == '0));
endmodule

// File: rtl/hdc_post_corrector.sv
module hdc_post_corrector
  import hdc_pkg::*;
#(
  parameter  int CW   = 16,
  parameter  int TAPS = 4,
  localparam int AAW  = $clog2(TAPS) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic signed [SW-1:0]  x_in,
  input  logic                  bypass,
  input  logic                  run_en,
  input  logic                  cfg_we,
  input  logic [AAW-1:0]        cfg_addr,
  input  logic [CW-1:0]         cfg_data,
  output logic signed [SW-1:0]  y_out
);
  localparam int AW    = CW + TW + $clog2(UP * TAPS * 2) + 1;
  localparam int SHIFT = (CW - 1) + UPL;   // Q1.15 scale plus smoothing divide
  localparam int ALIGN = 4;                // registers ahead of the output stage

  samp_t [UP-1:0]          w;
  term_t [UP-1:0]          sq_cur, sq_prev, cu_cur, cu_prev;
  logic [TAPS-1:0][CW-1:0] c2, c3;
  logic signed [AW-1:0]    acc;
  logic signed [AW-1:0]    corr;
  logic signed [AW:0]      diff;
  samp_t [ALIGN-1:0]       dly_q;
  samp_t                   aligned;
  logic [2:0]              age_q;

  hdc_interp u_interp (.clk(clk), .rst(rst), .x_i(x_in), .w_o(w));

  hdc_power u_power (.clk(clk), .rst(rst), .w_i(w),
    .sq_cur(sq_cur), .sq_prev(sq_prev), .cu_cur(cu_cur), .cu_prev(cu_prev));

  hdc_coef_bank #(.CW(CW), .TAPS(TAPS)) u_coef (.clk(clk), .rst(rst),
    .run_en(run_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .c2_o(c2), .c3_o(c3));

  hdc_branch_acc #(.CW(CW), .TAPS(TAPS), .AW(AW)) u_acc (.clk(clk), .rst(rst),
    .sq_cur(sq_cur), .sq_prev(sq_prev), .cu_cur(cu_cur), .cu_prev(cu_prev),
    .c2_i(c2), .c3_i(c3), .acc_o(acc));

  assign aligned = dly_q[ALIGN-1];
  assign corr    = acc >>> SHIFT;
  assign diff    = (AW+1)'(aligned) - (AW+1)'(corr);

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= '0;
      y_out <= '0;
      age_q <= '0;
    end else begin
      dly_q <= {dly_q[ALIGN-2:0], x_in};
      y_out <= bypass ? aligned : sat_samp(longint'(diff));
      if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end
  end

  // R8: bypassed output is the input of five edges back
  assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    ((age_q >= 3'd5) && $past(bypass)) |-> (y_out == $past(x_in, 5)));
  // R1: output cleared on the edge after reset
  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (y_out == '0));
endmodule

// File: tb/hdc_post_corrector_bench.sv
`timescale 1ns/1ps
module hdc_post_corrector_bench;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic signed [11:0] x_in = '0;
  logic              bypass = 1'b0;
  logic              run_en = 1'b0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_addr = '0;
  logic [15:0]       cfg_data = '0;
  logic signed [11:0] y_out;

  always #4 clk = ~clk;   // 125 MHz

  hdc_post_corrector u_hdc_post_corrector (.clk(clk), .rst(rst), .x_in(x_in),
    .bypass(bypass), .run_en(run_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .y_out(y_out));

  typedef struct { int due; int expv; string tag; } item_t;
  item_t sb[$];

  int n_chk = 0, n_fail = 0, cyc = 0;
  int hx0 = 0, hx1 = 0, hx2 = 0;
  int mc2[4] = '{0, 0, 0, 0};
  int mc3[4] = '{0, 0, 0, 0};
  int sat_hi = 0, sat_lo = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint fdiv(input longint a, input longint b);
    longint r;
    r = a % b;
    if (r < 0) r += b;
    return (a - r) / b;
  endfunction

  // Expected output for the newest sample, from R3..R8 restated directly.
  function automatic int model();
    longint s[7], c[7];
    longint a, b, wv, acc, v;
    int q;
    for (int i = 0; i < 7; i++) begin
      a  = (i < 4) ? hx0 : hx1;
      b  = (i < 4) ? hx1 : hx2;
      q  = (i < 4) ? 3 - i : 7 - i;
      wv = fdiv(q * a + (4 - q) * b, 4);
      s[i] = fdiv(wv * wv, 2048);
      c[i] = fdiv(wv * wv * wv, 4194304);
    end
    acc = 0;
    for (int j = 0; j < 4; j++)
      for (int k = 0; k < 4; k++)
        acc += longint'(mc2[j]) * s[j+k] + longint'(mc3[j]) * c[j+k];
    if (bypass) return hx0;
    v = hx0 - fdiv(acc, 131072);
    if (v > 2047)  begin sat_hi++; return 2047;  end
    if (v < -2048) begin sat_lo++; return -2048; end
    return int'(v);
  endfunction

  task automatic step(input int xv, input bit chk, input string tag);
    @(negedge clk);
    cfg_we = 1'b0;
    x_in = 12'(xv);
    hx2 = hx1; hx1 = hx0; hx0 = xv;
    if (chk) sb.push_back('{cyc + 5, model(), tag});
  endtask

  task automatic quiesce();
    for (int i = 0; i < 6; i++) step($urandom_range(0, 4095) - 2048, 1'b0, "");
  endtask

  // R9 write: addr bit2 = branch (0 square, 1 cube), bits1:0 = tap
  task automatic wr(input bit br, input int tap, input int val);
    cfg_addr = {br, 2'(tap)};
    cfg_data = 16'(val);
    cfg_we   = 1'b1;
    if (!run_en) begin
      if (br) mc3[tap] = val; else mc2[tap] = val;
    end
    step(0, 1'b0, "");
  endtask

  // scoreboard monitor: outputs due four edges after their sampling edge
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      check(int'(y_out) == it.expv, it.tag, int'(y_out), it.expv);
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(y_out == 0, "R1 reset output", int'(y_out), 0);
    rst = 1'b0;

    // R11 / R2: cleared coefficients after reset, output is the delayed input
    for (int i = 0; i < 30; i++) step($urandom_range(0, 4095) - 2048, 1'b1, "R11 R2 R1 zero coefs");
    for (int i = 0; i < 6; i++) step((i == 2) ? 1500 : 0, 1'b1, "R2 impulse latency");

    // R9 / R3 / R4 / R5: single square tap
    quiesce();
    wr(1'b0, 0, 16384);
    for (int i = 0; i < 12; i++) step((i == 3) ? 2000 : -300, 1'b1, "R3 R4 R9 square tap0");
    for (int i = 0; i < 30; i++) step($urandom_range(0, 4095) - 2048, 1'b1, "R5 R6 square tap0 random");

    // R5: mixed taps in both branches
    quiesce();
    wr(1'b1, 2, -8192);
    wr(1'b0, 3, 12000);
    wr(1'b1, 1, 20000);
    for (int i = 0; i < 24; i++) step((i % 2) ? 1900 : -1800, 1'b1, "R5 alternating");
    for (int i = 0; i < 32; i++) step((i * 257) % 4096 - 2048, 1'b1, "R5 R6 ramp");
    for (int i = 0; i < 30; i++) step($urandom_range(0, 4095) - 2048, 1'b1, "R5 R4 random");

    // R8: bypass with non-zero coefficients
    quiesce();
    bypass = 1'b1;
    for (int i = 0; i < 20; i++) step($urandom_range(0, 4095) - 2048, 1'b1, "R8 bypass");
    quiesce();
    bypass = 1'b0;

    // R10: writes while running are ignored
    run_en = 1'b1;
    wr(1'b0, 0, -32768);
    wr(1'b1, 2, 30000);
    for (int i = 0; i < 24; i++) step($urandom_range(0, 4095) - 2048, 1'b1, "R10 locked write");
    quiesce();
    run_en = 1'b0;

    // R7: drive both rails
    for (int j = 0; j < 4; j++) begin wr(1'b0, j, -32768); wr(1'b1, j, 0); end
    for (int i = 0; i < 12; i++) step(2047, 1'b1, "R7 positive rail");
    quiesce();
    for (int j = 0; j < 4; j++) begin wr(1'b0, j, 0); wr(1'b1, j, 32767); end
    for (int i = 0; i < 12; i++) step(2047, 1'b1, "R7 negative rail");
    for (int i = 0; i < 12; i++) step(-2048, 1'b1, "R7 negative input");
    check(sat_hi > 0, "R7 upper rail reached", sat_hi, 1);
    check(sat_lo > 0, "R7 lower rail reached", sat_lo, 1);

    for (int i = 0; i < 8; i++) step(0, 1'b0, "");
    check(sb.size() == 0, "R2 all outputs seen", sb.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule